// File: doc/BRIEF.md
# Four-Channel External Interrupt Sense Controller

This block watches four external interrupt pins and turns activity on each into an interrupt request line. Each channel has a 2-bit sense mode. The mode selects one of four triggers: the pin being held low, any change of the pin, a falling edge, or a rising edge. Each pin passes through a two-flop synchroniser. Edges are judged by comparing the newest synchronised sample with the one taken a clock earlier. An edge event sets a per-channel pending flag, and a one-cycle acknowledge pulse clears that flag. In low-level mode nothing is latched: the request simply follows the synchronised pin.

Software sets the block up through two 8-bit registers, each with its own write strobe and a shared write-data bus. The sense register holds the four 2-bit mode fields. The enable register gates the channels. A channel's request reaches its output only when its enable bit and the global interrupt-enable input are both 1. Pending flags still latch while a channel is gated off. Any value that reaches a pin is sensed, including a value the system itself drives onto it. This lets software raise an interrupt on purpose.

Changing a channel's mode field clears that channel's pending flag in the same cycle. As a result, reinterpreting the current pin samples under the new mode cannot record a false event.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the sense register reads 0x00, the enable register reads 0x00 and all four request outputs are 0.
- R2: A write to the sense register stores the data and reads it back. Channel n uses bits [2n+1:2n], with bit 2n+1 as the high mode bit. The codes are: 00 low level, 01 any change, 10 falling edge, 11 rising edge.
- R3: In the enable register, bit n enables channel n for n = 0..3. Writes to bits 7:4 are ignored, and those bits always read as 0.
- R4: irq_o[n] is 1 only when channel n has a request and its enable bit and irq_global_en_i are both 1.
- R5: In mode 00, irq_o[n] rises at the second clock edge after pin n goes low. It stays high for as long as the pin stays low, and it falls at the second edge after the pin returns high.
- R6: In mode 01, both a falling and a rising transition of the pin set the pending request.
- R7: In mode 10, a falling transition sets the pending request and a rising transition does not.
- R8: In mode 11, a rising transition sets the pending request and a falling transition does not.
- R9: A pin pulse held for one full clock period is detected in edge modes.
- R10: An edge event sets the pending flag while the channel is disabled. The request appears as soon as the channel is enabled.
- R11: A one-cycle pulse on ack_i[n] clears pending flag n. If a new event occurs in the same cycle as the acknowledge, the flag stays set.
- R12: A sense write that changes channel n's field clears its pending flag and suppresses any event seen in that cycle. A write that leaves the field unchanged keeps the flag.
- R13: In edge modes, a pin change appears on irq_o at the third clock edge after it is applied, and not at the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_global_en_i | input | 1 | Global interrupt enable |
| wr_sense_i | input | 1 | Write strobe for the sense register |
| wr_mask_i | input | 1 | Write strobe for the enable register |
| wdata_i | input | 8 | Register write data |
| pin_i | input | 4 | External interrupt pins, asynchronous |
| ack_i | input | 4 | Per-channel pending-flag acknowledge pulses |
| sense_rd_o | output | 8 | Sense register read value |
| mask_rd_o | output | 8 | Enable register read value, bits 7:4 zero |
| irq_o | output | 4 | Per-channel interrupt requests |

## Verification
Every channel is run in every mode with a falling transition followed by a rising one. The sequence shows which modes react to which direction, and it shows that the field position decodes to the right channel. A sustained low pin separates level sensing from latching, and single-cycle pulses show the minimum detectable width. The remaining sequences target specific cases:
- An event timed into the acknowledge cycle separates correct flag priority from a plain clear.
- Identical versus changed sense writes, timed onto a live edge, separate the reload guard from unconditional clearing.
- Toggling the enable bit and the global enable around an already latched event confirms that gating acts only at the output.

// File: rtl/eis_pkg.sv
package eis_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eis_rst_sync.sv
module eis_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stg_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end
  assign rst_sync_no = stg_q[1];
endmodule

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[0] <= '0;
          else         stg_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate
  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eis_regs.sv
module eis_regs #(
  parameter int NCH = 4,
  localparam int RW = 2 * NCH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_sense_i,
  input  logic          wr_mask_i,
  input  logic [RW-1:0] wdata_i,
  output logic [RW-1:0] sense_o,
  output logic [NCH-1:0] en_o,
  output logic [RW-1:0] mask_rd_o,
  output logic [NCH-1:0] reload_o
);
  logic [RW-1:0]  sense_q, sense_d;
  logic [NCH-1:0] en_q, en_d;

  always_comb begin
    sense_d = sense_q;
    if (wr_sense_i) sense_d = wdata_i;
    en_d = en_q;
    if (wr_mask_i) en_d = wdata_i[NCH-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      en_q    <= '0;
    end else begin
      sense_q <= sense_d;
      en_q    <= en_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_reload
      assign reload_o[g] = wr_sense_i && (wdata_i[2*g +: 2] != sense_q[2*g +: 2]);
    end
  endgenerate

  assign sense_o   = sense_q;
  assign en_o      = en_q;
  assign mask_rd_o = {{(RW-NCH){1'b0}}, en_q};
endmodule

// File: rtl/eis_chan.sv
module eis_chan
  import eis_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  sense_e mode_i,
  input  logic   cur_i,
  input  logic   reload_i,
  input  logic   ack_i,
  output logic   prev_o,
  output logic   pend_o,
  output logic   req_o
);
  logic prev_q, pend_q, pend_d, evt;

  always_comb begin
    unique case (mode_i)
      SENSE_ANY:  evt = cur_i ^ prev_q;
      SENSE_FALL: evt = prev_q & ~cur_i;
      SENSE_RISE: evt = ~prev_q & cur_i;
      default:    evt = 1'b0;
    endcase
    pend_d = pend_q;
    if (reload_i)   pend_d = 1'b0;
    else if (evt)   pend_d = 1'b1;
    else if (ack_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= cur_i;
      pend_q <= pend_d;
    end
  end

  assign prev_o = prev_q;
  assign pend_o = pend_q;
  assign req_o  = (mode_i == SENSE_LOW) ? ~cur_i : pend_q;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int NCH = 4,
  localparam int RW = 2 * NCH
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           irq_global_en_i,
  input  logic           wr_sense_i,
  input  logic           wr_mask_i,
  input  logic [RW-1:0]  wdata_i,
  input  logic [NCH-1:0] pin_i,
  input  logic [NCH-1:0] ack_i,
  output logic [RW-1:0]  sense_rd_o,
  output logic [RW-1:0]  mask_rd_o,
  output logic [NCH-1:0] irq_o
);
  logic           rst_ns;
  logic [NCH-1:0] cur_w, prev_w, pend_w, reload_w, req_w, en_w;

  eis_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_ns)
  );

  eis_sync #(.W(NCH), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ns),
    .d_i    (pin_i),
    .q_o    (cur_w)
  );

  eis_regs #(.NCH(NCH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ns),
    .wr_sense_i (wr_sense_i),
    .wr_mask_i  (wr_mask_i),
    .wdata_i    (wdata_i),
    .sense_o    (sense_rd_o),
    .en_o       (en_w),
    .mask_rd_o  (mask_rd_o),
    .reload_o   (reload_w)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      eis_chan u_chan (
        .clk_i    (clk_i),
        .rst_ni   (rst_ns),
        .mode_i   (sense_e'(sense_rd_o[2*g +: 2])),
        .cur_i    (cur_w[g]),
        .reload_i (reload_w[g]),
        .ack_i    (ack_i[g]),
        .prev_o   (prev_w[g]),
        .pend_o   (pend_w[g]),
        .req_o    (req_w[g])
      );
    end
  endgenerate

  assign irq_o = req_w & en_w & {NCH{irq_global_en_i}};
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int NCH = 4,
  localparam int RW = 2 * NCH
) (
  input logic           clk,
  input logic           rst_n,
  input logic           gie,
  input logic [RW-1:0]  sense_rd,
  input logic [RW-1:0]  mask_rd,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] cur,
  input logic [NCH-1:0] prev,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] reload,
  input logic [NCH-1:0] ack
);
  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_rd[RW-1:NCH] == '0);

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chk
      // R4
      gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[g] |-> (mask_rd[g] && gie));
      // R5
      level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_rd[2*g +: 2] == 2'b00 && mask_rd[g] && gie) |-> (irq[g] == !cur[g]));
      // R8
      rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_rd[2*g +: 2] == 2'b11 && !prev[g] && cur[g] && !reload[g]) |=> pend[g]);
      // R11
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[g] && (cur[g] == prev[g]) && !reload[g]) |=> !pend[g]);
      // R11
      ack_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[g] && sense_rd[2*g +: 2] == 2'b01 && (cur[g] != prev[g]) && !reload[g]) |=> pend[g]);
      // R12
      reload_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload[g] |=> !pend[g]);
    end
  endgenerate
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NCH(NCH)) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ns),
  .gie      (irq_global_en_i),
  .sense_rd (sense_rd_o),
  .mask_rd  (mask_rd_o),
  .irq      (irq_o),
  .cur      (cur_w),
  .prev     (prev_w),
  .pend     (pend_w),
  .reload   (reload_w),
  .ack      (ack_i)
);

// File: tb/ext_irq_sense_bench.sv
`timescale 1ns/1ps
module ext_irq_sense_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gie = 1'b0;
  logic       wr_s = 1'b0;
  logic       wr_m = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [3:0] pin = 4'hF;
  logic [3:0] ack = 4'h0;
  logic [7:0] sense_rd, mask_rd;
  logic [3:0] irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .irq_global_en_i (gie),
    .wr_sense_i      (wr_s),
    .wr_mask_i       (wr_m),
    .wdata_i         (wdata),
    .pin_i           (pin),
    .ack_i           (ack),
    .sense_rd_o      (sense_rd),
    .mask_rd_o       (mask_rd),
    .irq_o           (irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr_sense(input logic [7:0] v);
    wr_s = 1'b1; wdata = v;
    tick(1);
    wr_s = 1'b0;
  endtask

  task automatic wr_mask(input logic [7:0] v);
    wr_m = 1'b1; wdata = v;
    tick(1);
    wr_m = 1'b0;
  endtask

  task automatic ack_pulse(input int ch);
    ack[ch] = 1'b1;
    tick(1);
    ack[ch] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 sense", sense_rd, 8'h00);
    chk("R1 mask", mask_rd, 8'h00);
    chk("R1 irq", {4'h0, irq}, 8'h00);
  endtask

  task automatic t_regs;
    wr_sense(8'hE4);
    chk("R2 sense readback", sense_rd, 8'hE4);
    wr_mask(8'hFF);
    chk("R3 mask readback", mask_rd, 8'h0F);
    wr_mask(8'hF0);
    chk("R3 reserved ignored", mask_rd, 8'h00);
    chk("R3 irq none", {4'h0, irq}, 8'h00);
    wr_sense(8'h00);
    tick(4);
  endtask

  task automatic t_modes;
    for (int ch = 0; ch < 4; ch++) begin
      for (int m = 0; m < 4; m++) begin
        logic [3:0] bit_v;
        logic [7:0] fall_e, rise_e;
        bit_v = 4'(1 << ch);
        wr_mask({4'h0, bit_v});
        wr_sense(8'(m << (2 * ch)));
        tick(4);
        chk("R2 idle", {4'h0, irq}, 8'h00);
        if (m == 0) begin
          pin[ch] = 1'b0;
          tick(1);
          chk("R5 not yet", {4'h0, irq}, 8'h00);
          tick(1);
          chk("R5 level on", {4'h0, irq}, {4'h0, bit_v});
          tick(6);
          chk("R5 level sustained", {4'h0, irq}, {4'h0, bit_v});
          pin[ch] = 1'b1;
          tick(2);
          chk("R5 level off", {4'h0, irq}, 8'h00);
        end else begin
          fall_e = (m == 1 || m == 2) ? {4'h0, bit_v} : 8'h00;
          rise_e = (m == 1 || m == 3) ? {4'h0, bit_v} : 8'h00;
          pin[ch] = 1'b0;
          tick(2);
          chk("R13 fall not yet", {4'h0, irq}, 8'h00);
          tick(1);
          chk(m == 1 ? "R6 fall" : (m == 2 ? "R7 fall" : "R8 fall"), {4'h0, irq}, fall_e);
          ack_pulse(ch);
          chk("R11 ack clears", {4'h0, irq}, 8'h00);
          pin[ch] = 1'b1;
          tick(2);
          chk("R13 rise not yet", {4'h0, irq}, 8'h00);
          tick(1);
          chk(m == 1 ? "R6 rise" : (m == 2 ? "R7 rise" : "R8 rise"), {4'h0, irq}, rise_e);
          ack_pulse(ch);
          chk("R11 ack clears", {4'h0, irq}, 8'h00);
        end
      end
    end
    wr_sense(8'h00);
    wr_mask(8'h00);
    tick(4);
  endtask

  task automatic t_pulse;
    wr_mask(8'h02);
    wr_sense(8'h08);
    tick(4);
    pin[1] = 1'b0;
    tick(1);
    pin[1] = 1'b1;
    tick(4);
    chk("R9 short low pulse falling", {4'h0, irq}, 8'h02);
    ack_pulse(1);
    wr_sense(8'h0C);
    tick(4);
    pin[1] = 1'b0;
    tick(1);
    pin[1] = 1'b1;
    tick(4);
    chk("R9 short low pulse rising", {4'h0, irq}, 8'h02);
    ack_pulse(1);
    wr_sense(8'h00);
    wr_mask(8'h00);
    tick(4);
  endtask

  task automatic t_mask;
    wr_sense(8'h20);
    tick(4);
    pin[2] = 1'b0;
    tick(4);
    chk("R10 masked hidden", {4'h0, irq}, 8'h00);
    wr_mask(8'h04);
    chk("R10 unmask shows", {4'h0, irq}, 8'h04);
    gie = 1'b0; #1;
    chk("R4 global off", {4'h0, irq}, 8'h00);
    gie = 1'b1; #1;
    chk("R4 global on", {4'h0, irq}, 8'h04);
    ack_pulse(2);
    chk("R11 ack after unmask", {4'h0, irq}, 8'h00);
    pin[2] = 1'b1;
    tick(4);
    wr_sense(8'h00);
    wr_mask(8'h00);
    tick(4);
  endtask

  task automatic t_collide;
    wr_mask(8'h01);
    wr_sense(8'h01);
    tick(4);
    pin[0] = 1'b0;
    tick(4);
    chk("R6 any set", {4'h0, irq}, 8'h01);
    pin[0] = 1'b1;
    tick(2);
    ack[0] = 1'b1;
    tick(1);
    ack[0] = 1'b0;
    chk("R11 event during ack keeps", {4'h0, irq}, 8'h01);
    ack_pulse(0);
    chk("R11 plain ack clears", {4'h0, irq}, 8'h00);
    wr_sense(8'h00);
    wr_mask(8'h00);
    tick(4);
  endtask

  task automatic t_reload;
    wr_mask(8'h08);
    wr_sense(8'h40);
    tick(4);
    pin[3] = 1'b0;
    tick(4);
    chk("R12 pending set", {4'h0, irq}, 8'h08);
    wr_sense(8'h40);
    chk("R12 same field keeps", {4'h0, irq}, 8'h08);
    wr_sense(8'hC0);
    chk("R12 changed field clears", {4'h0, irq}, 8'h00);
    pin[3] = 1'b1;
    tick(2);
    wr_sense(8'h80);
    tick(3);
    chk("R12 edge at mode change dropped", {4'h0, irq}, 8'h00);
    wr_sense(8'h00);
    wr_mask(8'h00);
    tick(4);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    gie = 1'b1;
    t_regs();
    t_modes();
    t_pulse();
    t_mask();
    t_collide();
    t_reload();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule